// File: doc/BRIEF.md
# Serial Stereo Gain Word Writer

This block programs a stereo gain controller that has a three-wire serial input. The 16-bit gain word holds two 8-bit trims, one for the left channel and one for the right. The controller's select, clock and data inputs are not wired to this block. They are three bit positions inside a 20-bit control word. Every change to them goes out as a whole control word through a separate bit-serial latch driver, which sits outside this block.

A request on `start` captures a base control word and a gain word. The block then emits the whole series of control words on a valid/ready interface towards the latch driver. First it opens the select line with two writes. Next it sends three writes for every gain bit: clock low, then high, then low. Last it closes with the untouched base word. When that final word has been accepted, the block raises `done` for one cycle. One update therefore costs 2 + 3·16 + 1 = 51 latch writes.

Top module: `gain_word_writer`

## Requirements
- R1: After reset, and whenever no update is running, `latch_valid`, `busy` and `done` are low. `latch_valid` is high for the whole of an update.
- R2: The first two words of an update equal the captured base word with bit 6 (select, active low) forced to 0.
- R3: In every gain-bit word, bit 6 is 0 and bit 8 (serial data) carries the gain bit. All bits other than 6, 7 and 8 equal the captured base word.
- R4: The gain bits are sent in order from bit 15 down to bit 0. For each bit, three consecutive words carry bit 7 (serial clock) as 0, then 1, then 0.
- R5: The last word of an update equals the captured base word exactly.
- R6: Each update produces exactly 51 accepted transfers (`latch_valid` and `latch_ready` both high at a clock edge).
- R7: While `latch_valid` is high and `latch_ready` is low, the next word neither advances nor changes.
- R8: `done` is high for exactly one cycle, in the cycle after the final word is accepted. In that cycle `busy` is already low.
- R9: A `start` while `busy` is high is ignored. Changes on `base_word` or `gain_word` after capture do not alter the words of the update in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request an update; taken only when idle |
| base_word | input | 20 | Control word whose other bits are preserved |
| gain_word | input | 16 | Left/right gain trims, sent MSB first |
| latch_valid | output | 1 | A control word is offered to the latch driver |
| latch_ready | input | 1 | Latch driver can take the offered word |
| latch_word | output | 20 | Control word offered to the latch driver |
| busy | output | 1 | An update is in progress |
| done | output | 1 | One-cycle pulse after the final word is accepted |

## Verification
The checker assumes that the latch driver's `latch_ready` may be held low for any number of cycles, so it demands stability only across stalls. It also assumes that `start` is sampled only together with `busy`. The bench drives `latch_ready` always high, from a pseudo-random pattern and from a sparse pattern, and it changes `base_word` and `gain_word` only at the negative edge. It also issues a second `start`, with different values, in the middle of an update. This exercises the ignore rule without breaking these assumptions.

// File: rtl/gainwr_pkg.sv
package gainwr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_SHIFT = 2'd2,
        PH_CLOSE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CK_LEAD = 2'd0,
        CK_HIGH = 2'd1,
        CK_TAIL = 2'd2
    } clk_step_e;

    typedef struct packed {
        phase_e    phase;
        clk_step_e step;
    } seq_pos_t;

    function automatic clk_step_e next_step(clk_step_e s);
        case (s)
            CK_LEAD: return CK_HIGH;
            CK_HIGH: return CK_TAIL;
            default: return CK_LEAD;
        endcase
    endfunction

    function automatic logic step_clock_level(clk_step_e s);
        return (s == CK_HIGH);
    endfunction

endpackage

// File: rtl/gainwr_capture.sv
module gainwr_capture #(
    parameter int CTRL_W = 20,
    parameter int GAIN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [CTRL_W-1:0] base_in,
    input  logic [GAIN_W-1:0] gain_in,
    output logic [CTRL_W-1:0] base_q,
    output logic [GAIN_W-1:0] gain_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            gain_q <= '0;
        end else if (launch) begin
            base_q <= base_in;
            gain_q <= gain_in;
        end
    end
endmodule

// File: rtl/gainwr_seq.sv
module gainwr_seq
    import gainwr_pkg::*;
#(
    parameter int GAIN_W      = 16,
    parameter int OPEN_WRITES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       xfer_ready,
    output logic                       xfer_valid,
    output logic                       busy,
    output logic                       done,
    output logic                       launch,
    output seq_pos_t                   pos,
    output logic [$clog2(GAIN_W)-1:0]  bit_idx
);
    localparam int IDX_W = $clog2(GAIN_W);
    localparam int OCW   = (OPEN_WRITES > 1) ? $clog2(OPEN_WRITES) : 1;

    phase_e          phase_q;
    clk_step_e       step_q;
    logic [IDX_W-1:0] idx_q;
    logic [OCW-1:0]  open_cnt_q;
    logic            done_q;
    logic            fire;

    assign xfer_valid = (phase_q != PH_IDLE);
    assign busy       = xfer_valid;
    assign launch     = start && (phase_q == PH_IDLE);
    assign fire       = xfer_valid && xfer_ready;
    assign done       = done_q;
    assign pos        = '{phase: phase_q, step: step_q};
    assign bit_idx    = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            step_q     <= CK_LEAD;
            idx_q      <= '0;
            open_cnt_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (launch) begin
                        phase_q    <= PH_OPEN;
                        open_cnt_q <= '0;
                    end
                end
                PH_OPEN: begin
                    if (fire) begin
                        if (open_cnt_q == OCW'(OPEN_WRITES - 1)) begin
                            phase_q <= PH_SHIFT;
                            idx_q   <= IDX_W'(GAIN_W - 1);
                            step_q  <= CK_LEAD;
                        end else begin
                            open_cnt_q <= open_cnt_q + 1'b1;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (fire) begin
                        if (step_q == CK_TAIL) begin
                            step_q <= CK_LEAD;
                            if (idx_q == '0) begin
                                phase_q <= PH_CLOSE;
                            end else begin
                                idx_q <= idx_q - 1'b1;
                            end
                        end else begin
                            step_q <= next_step(step_q);
                        end
                    end
                end
                default: begin
                    if (fire) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/gainwr_compose.sv
module gainwr_compose
    import gainwr_pkg::*;
#(
    parameter int CTRL_W  = 20,
    parameter int GAIN_W  = 16,
    parameter int CS_POS  = 6,
    parameter int SCK_POS = 7,
    parameter int SDI_POS = 8
) (
    input  logic [CTRL_W-1:0]         base_q,
    input  logic [GAIN_W-1:0]         gain_q,
    input  seq_pos_t                  pos,
    input  logic [$clog2(GAIN_W)-1:0] bit_idx,
    output logic [CTRL_W-1:0]         word
);
    logic gain_bit;
    assign gain_bit = gain_q[bit_idx];

    always_comb begin
        word = base_q;
        case (pos.phase)
            PH_OPEN: begin
                word[CS_POS] = 1'b0;
            end
            PH_SHIFT: begin
                word[CS_POS]  = 1'b0;
                word[SDI_POS] = gain_bit;
                word[SCK_POS] = step_clock_level(pos.step);
            end
            default: word = base_q;
        endcase
    end
endmodule

// File: rtl/gain_word_writer.sv
module gain_word_writer
    import gainwr_pkg::*;
#(
    parameter int CTRL_W      = 20,
    parameter int GAIN_W      = 16,
    parameter int CS_POS      = 6,
    parameter int SCK_POS     = 7,
    parameter int SDI_POS     = 8,
    parameter int OPEN_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CTRL_W-1:0] base_word,
    input  logic [GAIN_W-1:0] gain_word,
    output logic              latch_valid,
    input  logic              latch_ready,
    output logic [CTRL_W-1:0] latch_word,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(GAIN_W);

    logic              launch;
    logic [CTRL_W-1:0] base_q;
    logic [GAIN_W-1:0] gain_q;
    seq_pos_t          pos;
    logic [IDX_W-1:0]  bit_idx;

    gainwr_capture #(.CTRL_W(CTRL_W), .GAIN_W(GAIN_W)) u_cap (
        .clk(clk), .rst(rst), .launch(launch),
        .base_in(base_word), .gain_in(gain_word),
        .base_q(base_q), .gain_q(gain_q)
    );

    gainwr_seq #(.GAIN_W(GAIN_W), .OPEN_WRITES(OPEN_WRITES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .xfer_ready(latch_ready),
        .xfer_valid(latch_valid), .busy(busy), .done(done),
        .launch(launch), .pos(pos), .bit_idx(bit_idx)
    );

    gainwr_compose #(
        .CTRL_W(CTRL_W), .GAIN_W(GAIN_W),
        .CS_POS(CS_POS), .SCK_POS(SCK_POS), .SDI_POS(SDI_POS)
    ) u_cmp (
        .base_q(base_q), .gain_q(gain_q), .pos(pos),
        .bit_idx(bit_idx), .word(latch_word)
    );
endmodule

// File: rtl/gainwr_chk.sv
module gainwr_chk #(
    parameter int CTRL_W  = 20,
    parameter int CS_POS  = 6,
    parameter int SCK_POS = 7,
    parameter int SDI_POS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CTRL_W-1:0] base_word,
    input logic              latch_valid,
    input logic              latch_ready,
    input logic [CTRL_W-1:0] latch_word,
    input logic              busy,
    input logic              done
);
    localparam logic [CTRL_W-1:0] SERIAL_MASK =
        (CTRL_W'(1) << CS_POS) | (CTRL_W'(1) << SCK_POS) | (CTRL_W'(1) << SDI_POS);

    logic [CTRL_W-1:0] seen_base;
    always_ff @(posedge clk) begin
        if (rst)                 seen_base <= '0;
        else if (start && !busy) seen_base <= base_word;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !latch_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_valid && !latch_ready) |=> (latch_valid && $stable(latch_word)));

    // R3
    other_bits_chk: assert property (@(posedge clk) disable iff (rst)
        latch_valid |-> (((latch_word ^ seen_base) & ~SERIAL_MASK) == '0));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(latch_valid && latch_ready) && !busy));

    // R5
    close_word_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(latch_word) == seen_base));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !latch_ready) |=> busy);
endmodule

bind gain_word_writer gainwr_chk #(
    .CTRL_W(CTRL_W), .CS_POS(CS_POS), .SCK_POS(SCK_POS), .SDI_POS(SDI_POS)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .base_word(base_word),
    .latch_valid(latch_valid), .latch_ready(latch_ready),
    .latch_word(latch_word), .busy(busy), .done(done)
);

// File: tb/sim_gain_word_writer.sv
`timescale 1ns/1ps
module sim_gain_word_writer;
    localparam int CW = 20;
    localparam int GW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] base_word = '0;
    logic [GW-1:0] gain_word = '0;
    logic          latch_ready = 1'b0;
    logic          latch_valid, busy, done;
    logic [CW-1:0] latch_word;

    always #2 clk = ~clk;

    gain_word_writer u0 (
        .clk(clk), .rst(rst), .start(start), .base_word(base_word),
        .gain_word(gain_word), .latch_valid(latch_valid),
        .latch_ready(latch_ready), .latch_word(latch_word),
        .busy(busy), .done(done)
    );

    integer tests = 0, fails = 0, cycles = 0, xfers = 0;
    logic [CW-1:0] qw[$];
    string         qt[$];
    bit            exp_done = 0, fin = 0;
    bit            pend_start = 0;
    logic [CW-1:0] pend_base = '0;
    logic [GW-1:0] pend_gain = '0;
    int            rmode = 0;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic enqueue(input logic [CW-1:0] b, input logic [GW-1:0] g);
        logic [CW-1:0] w;
        qw.push_back(b & ~(20'h1 << 6)); qt.push_back("R2");
        qw.push_back(b & ~(20'h1 << 6)); qt.push_back("R2");
        for (int k = GW - 1; k >= 0; k--) begin
            w = (b & ~20'h001C0) | (CW'(g[k]) << 8);
            qw.push_back(w);            qt.push_back("R4");
            qw.push_back(w | 20'h00080); qt.push_back("R4");
            qw.push_back(w);            qt.push_back("R3");
        end
        qw.push_back(b); qt.push_back("R5");
        xfers = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        cycles++;
        case (rmode)
            0: latch_ready = 1'b1;
            1: latch_ready = lfsr[0];
            default: latch_ready = (lfsr[2:0] == 3'd0);
        endcase
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        chk(done == exp_done, "R8 done", 32'(done), 32'(exp_done));
        if (exp_done) begin
            chk(busy == 1'b0, "R8 busy", 32'(busy), 32'd0);
            chk(xfers == 51, "R6 count", xfers, 51);
            fin = 1;
        end
        exp_done = 0;
        chk(latch_valid == (qw.size() != 0), "R1 valid", 32'(latch_valid), 32'(qw.size() != 0));
        if (latch_valid && qw.size() != 0) begin
            chk(latch_word == qw[0], latch_ready ? qt[0] : "R7", 32'(latch_word), 32'(qw[0]));
            if (latch_ready) begin
                void'(qw.pop_front()); void'(qt.pop_front());
                xfers++;
                if (qw.size() == 0) exp_done = 1;
            end
        end
        start = pend_start;
        if (pend_start) begin
            base_word = pend_base;
            gain_word = pend_gain;
            if (qw.size() == 0) enqueue(pend_base, pend_gain);
        end
        pend_start = 0;
    endtask

    task automatic run_update(input logic [CW-1:0] b, input logic [GW-1:0] g,
                              input int mode, input bit intrude);
        int n = 0;
        rmode = mode;
        fin = 0;
        pend_start = 1; pend_base = b; pend_gain = g;
        while (!fin && n < 3000) begin
            tick();
            n++;
            if (intrude && n == 30) begin
                // R9: second request and changed inputs during the update
                pend_start = 1; pend_base = ~b; pend_gain = ~g;
            end
        end
        if (!fin) chk(1'b0, "watchdog", n, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(latch_valid == 1'b0, "R1 reset valid", 32'(latch_valid), 0);
        chk(busy == 1'b0, "R1 reset busy", 32'(busy), 0);
        chk(done == 1'b0, "R1 reset done", 32'(done), 0);
        run_update(20'h5A5A5, 16'hC4C4, 0, 0);
        run_update(20'hFFFFF, 16'h0000, 1, 0);
        run_update(20'h00000, 16'hFFFF, 2, 0);
        run_update(20'h3C1C0, 16'h8001, 1, 1);
        run_update(20'hABCDE, 16'h1234, 0, 1);
        repeat (3) tick();
        chk(latch_valid == 1'b0, "R9 no extra update", 32'(latch_valid), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule